// File: doc/BRIEF.md
# Block-Circulant Matrix-Vector Multiplier

This block computes y = W·x for a weight matrix built from square 4×4 circulant tiles. Each tile is fully determined by one 4-element defining vector. Instead of storing the tiles, the block holds the 4-point spectrum of every tile in a constant on-chip table, computed at elaboration time. The tile grid is `ROW_BLKS` tiles tall and `COL_BLKS` tiles wide.

The input vector arrives as `COL_BLKS` blocks of four signed 16-bit samples over a valid/ready stream. Each block is turned into its 4-point spectrum using adders only. The spectrum is then multiplied bin by bin with the stored tile spectra and summed into one frequency-domain accumulator set per row-block, spending one cycle per row-block. Once the last column-block has been folded in, each row-block passes through a single inverse transform and a divide by four. The result is saturated to 16 bits and offered on the output stream, row-block 0 first.

A producer may hold `in_valid` high at any time; a block transfers only on a cycle where `in_valid` and `in_ready` are both high. The consumer may stall the output with `out_ready` low for any number of cycles. While it stalls, the offered block does not change. A new input vector is not accepted until every output block of the previous one has been taken.

Top module: `circ_blk_mvm`

## Requirements
- R1: Tile (r,c) has entry W[i][j] = w_rc[(j−i) mod 4], so row i is the defining vector rotated right by i places. Output block r, element i, equals the exact integer sum over c and j of W[i][j]·x_c[j]. Element e of any 64-bit data bus sits at bits [16e+15:16e], signed two's complement.
- R2: The defining vector of tile (r,c) has element k equal to (((37r + 23c + 11k + 5) mod 61) − 30)·256.
- R3: An output element whose exact sum exceeds 32767 reads 32767, and one below −32768 reads −32768.
- R4: `in_ready` and `out_valid` are never high together. After reset, and after each completed vector, `in_ready` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high on the next cycle and `out_data` keeps its value.
- R6: After the cycle in which an input block transfers, `in_ready` is low for exactly `ROW_BLKS` cycles. After that, `in_ready` is high again if more column-blocks are due, or `out_valid` is high if the block was the last one.
- R7: `done` is high for exactly the one cycle after the handshake of the last output block of a vector, and `in_ready` is high in that cycle.
- R8: Output blocks of a vector appear in row-block order 0 to `ROW_BLKS`−1, one per output handshake.
- R9: Column-blocks are taken in arrival order, the first one being column 0. Each vector's results are independent of any earlier vector.
- R10: During reset, and on the first cycle after it, `out_valid` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block accepts an input block |
| in_data | input | 64 | Four signed 16-bit input samples |
| out_valid | output | 1 | Output block offered |
| out_ready | input | 1 | Consumer accepts the output block |
| out_data | output | 64 | Four saturated signed 16-bit results |
| done | output | 1 | One-cycle pulse after the last output block |

## Verification
Once an input block is taken, `in_ready` must stay low for exactly `ROW_BLKS` cycles. For the last column-block, the first output block is due on the `ROW_BLKS`-th cycle after the transfer edge. Each following row-block is due on the cycle after the previous handshake, unless the consumer stalls. The bench samples on the falling edge: the driver counts falling edges from the transfer to check the quiet window and the arrival of `out_valid`. The monitor compares every handshaken block with a queued time-domain result, checks that stalled data holds, and expects `done` exactly one falling edge after the last handshake.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int BLK    = 4;
  localparam int DW     = 16;
  localparam int SW     = DW + 2;
  localparam int NFIELD = 6;
  // spectrum field order: bin0 re, bin1 re, bin1 im, bin2 re, bin3 re, bin3 im
  localparam int F_R0 = 0;
  localparam int F_R1 = 1;
  localparam int F_I1 = 2;
  localparam int F_R2 = 3;
  localparam int F_R3 = 4;
  localparam int F_I3 = 5;

  function automatic int tap_value(int r, int c, int k);
    return (((37 * r + 23 * c + 11 * k + 5) % 61) - 30) * 256;
  endfunction

  // conjugated spectrum of the defining vector: rows rotate right, so the
  // product is a circular correlation
  function automatic logic [NFIELD*SW-1:0] tile_spectrum(int r, int c);
    int w0, w1, w2, w3;
    logic [NFIELD*SW-1:0] f;
    w0 = tap_value(r, c, 0);
    w1 = tap_value(r, c, 1);
    w2 = tap_value(r, c, 2);
    w3 = tap_value(r, c, 3);
    f = '0;
    f[F_R0*SW +: SW] = SW'(w0 + w1 + w2 + w3);
    f[F_R1*SW +: SW] = SW'(w0 - w2);
    f[F_I1*SW +: SW] = SW'(w1 - w3);
    f[F_R2*SW +: SW] = SW'(w0 - w1 + w2 - w3);
    f[F_R3*SW +: SW] = SW'(w0 - w2);
    f[F_I3*SW +: SW] = SW'(w3 - w1);
    return f;
  endfunction

  typedef enum logic [1:0] {ST_TAKE, ST_MAC, ST_EMIT} seq_state_t;
endpackage

// File: rtl/cbm_fwd_dft4.sv
module cbm_fwd_dft4
  import cbm_pkg::*;
(
  input  logic [BLK*DW-1:0]    blk,
  output logic [NFIELD*SW-1:0] spec
);
  logic signed [SW-1:0] xe [BLK];

  always_comb begin
    for (int e = 0; e < BLK; e++) begin
      xe[e] = {{(SW-DW){blk[e*DW+DW-1]}}, blk[e*DW +: DW]};
    end
    spec = '0;
    spec[F_R0*SW +: SW] = xe[0] + xe[1] + xe[2] + xe[3];
    spec[F_R1*SW +: SW] = xe[0] - xe[2];
    spec[F_I1*SW +: SW] = xe[3] - xe[1];
    spec[F_R2*SW +: SW] = xe[0] - xe[1] + xe[2] - xe[3];
    spec[F_R3*SW +: SW] = xe[0] - xe[2];
    spec[F_I3*SW +: SW] = xe[1] - xe[3];
  end
endmodule

// File: rtl/cbm_tile_rom.sv
module cbm_tile_rom
  import cbm_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 3,
  parameter int RIW  = 1,
  parameter int CIW  = 2
) (
  input  logic [RIW-1:0]       row_idx,
  input  logic [CIW-1:0]       col_idx,
  output logic [NFIELD*SW-1:0] spec
);
  localparam int ENTRIES = ROWS * COLS;
  localparam int TW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [NFIELD*SW-1:0] tbl [ENTRIES];
  logic [TW-1:0] sel;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign tbl[r*COLS+c] = tile_spectrum(r, c);
    end
  end

  always_comb begin
    sel  = TW'(int'(row_idx) * COLS + int'(col_idx));
    spec = tbl[sel];
  end
endmodule

// File: rtl/cbm_mac_bank.sv
module cbm_mac_bank
  import cbm_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int ACC_W = 40,
  parameter int RIW   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mac_en,
  input  logic                    mac_load,
  input  logic [RIW-1:0]          mac_row,
  input  logic [NFIELD*SW-1:0]    xs,
  input  logic [NFIELD*SW-1:0]    ws,
  input  logic [RIW-1:0]          rd_row,
  output logic [NFIELD*ACC_W-1:0] rd_acc
);
  logic signed [ACC_W-1:0] acc  [ROWS][NFIELD];
  logic signed [ACC_W-1:0] prod [NFIELD];
  logic signed [ACC_W-1:0] xa   [NFIELD];
  logic signed [ACC_W-1:0] wa   [NFIELD];

  always_comb begin
    for (int f = 0; f < NFIELD; f++) begin
      xa[f] = {{(ACC_W-SW){xs[f*SW+SW-1]}}, xs[f*SW +: SW]};
      wa[f] = {{(ACC_W-SW){ws[f*SW+SW-1]}}, ws[f*SW +: SW]};
    end
    // real-only bins need one product each, the odd bins a full complex one
    prod[F_R0] = xa[F_R0] * wa[F_R0];
    prod[F_R2] = xa[F_R2] * wa[F_R2];
    prod[F_R1] = xa[F_R1] * wa[F_R1] - xa[F_I1] * wa[F_I1];
    prod[F_I1] = xa[F_R1] * wa[F_I1] + xa[F_I1] * wa[F_R1];
    prod[F_R3] = xa[F_R3] * wa[F_R3] - xa[F_I3] * wa[F_I3];
    prod[F_I3] = xa[F_R3] * wa[F_I3] + xa[F_I3] * wa[F_R3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int f = 0; f < NFIELD; f++) acc[r][f] <= '0;
      end
    end else if (mac_en) begin
      for (int f = 0; f < NFIELD; f++) begin
        acc[mac_row][f] <= mac_load ? prod[f] : acc[mac_row][f] + prod[f];
      end
    end
  end

  always_comb begin
    for (int f = 0; f < NFIELD; f++) rd_acc[f*ACC_W +: ACC_W] = acc[rd_row][f];
  end
endmodule

// File: rtl/cbm_inv_dft4.sv
module cbm_inv_dft4
  import cbm_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [NFIELD*ACC_W-1:0] acc,
  output logic [BLK*DW-1:0]       blk
);
  localparam int OW = ACC_W + 2;

  logic signed [OW-1:0] fe  [NFIELD];
  logic signed [OW-1:0] sum [BLK];
  logic signed [OW-1:0] q   [BLK];

  always_comb begin
    for (int f = 0; f < NFIELD; f++) begin
      fe[f] = {{(OW-ACC_W){acc[f*ACC_W+ACC_W-1]}}, acc[f*ACC_W +: ACC_W]};
    end
    sum[0] = fe[F_R0] + fe[F_R1] + fe[F_R2] + fe[F_R3];
    sum[1] = fe[F_R0] - fe[F_I1] - fe[F_R2] + fe[F_I3];
    sum[2] = fe[F_R0] - fe[F_R1] + fe[F_R2] - fe[F_R3];
    sum[3] = fe[F_R0] + fe[F_I1] - fe[F_R2] - fe[F_I3];
    for (int e = 0; e < BLK; e++) begin
      q[e] = sum[e] >>> 2;
      if ((&q[e][OW-1:DW-1]) || !(|q[e][OW-1:DW-1])) begin
        blk[e*DW +: DW] = q[e][DW-1:0];
      end else if (q[e][OW-1]) begin
        blk[e*DW +: DW] = {1'b1, {(DW-1){1'b0}}};
      end else begin
        blk[e*DW +: DW] = {1'b0, {(DW-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/circ_blk_mvm.sv
module circ_blk_mvm
  import cbm_pkg::*;
#(
  parameter int ROW_BLKS = 2,
  parameter int COL_BLKS = 3,
  parameter int ACC_W    = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BLK*DW-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BLK*DW-1:0]    out_data,
  output logic                 done
);
  localparam int RIW = (ROW_BLKS > 1) ? $clog2(ROW_BLKS) : 1;
  localparam int CIW = (COL_BLKS > 1) ? $clog2(COL_BLKS) : 1;
  localparam logic [RIW-1:0] ROW_LAST = RIW'(ROW_BLKS - 1);
  localparam logic [CIW-1:0] COL_LAST = CIW'(COL_BLKS - 1);

  seq_state_t state_q;
  logic [RIW-1:0] row_q;
  logic [CIW-1:0] col_q;
  logic [NFIELD*SW-1:0] xs_d, xs_q, ws;
  logic [NFIELD*ACC_W-1:0] rd_acc;
  logic done_q;
  logic mac_en;

  cbm_fwd_dft4 u_fwd (.blk(in_data), .spec(xs_d));

  cbm_tile_rom #(.ROWS(ROW_BLKS), .COLS(COL_BLKS), .RIW(RIW), .CIW(CIW)) u_rom (
    .row_idx(row_q), .col_idx(col_q), .spec(ws)
  );

  assign mac_en = (state_q == ST_MAC);

  cbm_mac_bank #(.ROWS(ROW_BLKS), .ACC_W(ACC_W), .RIW(RIW)) u_mac (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .mac_load(col_q == '0),
    .mac_row(row_q), .xs(xs_q), .ws(ws), .rd_row(row_q), .rd_acc(rd_acc)
  );

  cbm_inv_dft4 #(.ACC_W(ACC_W)) u_inv (.acc(rd_acc), .blk(out_data));

  assign in_ready  = (state_q == ST_TAKE);
  assign out_valid = (state_q == ST_EMIT);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TAKE;
      row_q   <= '0;
      col_q   <= '0;
      xs_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_TAKE: if (in_valid) begin
          xs_q    <= xs_d;
          row_q   <= '0;
          state_q <= ST_MAC;
        end
        ST_MAC: begin
          if (row_q == ROW_LAST) begin
            row_q <= '0;
            if (col_q == COL_LAST) begin
              col_q   <= '0;
              state_q <= ST_EMIT;
            end else begin
              col_q   <= col_q + 1'b1;
              state_q <= ST_TAKE;
            end
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_EMIT: if (out_ready) begin
          if (row_q == ROW_LAST) begin
            row_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_TAKE;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        default: state_q <= ST_TAKE;
      endcase
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_done_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
endmodule

// File: tb/circ_blk_mvm_tb.sv
module circ_blk_mvm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 2;
  localparam int COLS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_data = '0;
  logic out_valid;
  logic out_ready;
  logic [63:0] out_data;
  logic done;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [64:0] exp_q [$];
  int xbuf [COLS][4];

  circ_blk_mvm #(.ROW_BLKS(ROWS), .COL_BLKS(COLS), .ACC_W(40)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int tap(int r, int c, int k);
    return (((37 * r + 23 * c + 11 * k + 5) % 61) - 30) * 256;
  endfunction

  function automatic logic [15:0] sat16(longint v);
    if (v > 32767) return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  // R1 R2 R3: time-domain reference pushed into the scoreboard
  task automatic send_vec(input int gap);
    logic [63:0] pk;
    logic [63:0] blk;
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < 4; i++) begin
        longint s = 0;
        for (int c = 0; c < COLS; c++)
          for (int j = 0; j < 4; j++)
            s += longint'(tap(r, c, (j - i + 4) % 4)) * longint'(xbuf[c][j]);
        pk[16*i +: 16] = sat16(s);
      end
      exp_q.push_back({(r == ROWS - 1), pk});
    end
    for (int c = 0; c < COLS; c++) begin
      for (int e = 0; e < 4; e++) blk[16*e +: 16] = 16'(xbuf[c][e]);
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = blk;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
      // R6: quiet window of ROWS cycles after the transfer
      for (int k = 0; k < ROWS; k++) begin
        chk(!in_ready, "R6", "in_ready low after transfer", longint'(in_ready), 0);
        @(negedge clk);
      end
      if (c == COLS - 1)
        chk(out_valid, "R6", "out_valid due after last block", longint'(out_valid), 1);
      else
        chk(in_ready, "R6", "in_ready back for next block", longint'(in_ready), 1);
    end
  endtask

  // monitor and scoreboard
  bit stall = 1'b0;
  bit expd = 1'b0;
  logic [63:0] hold_d = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b0;
      stall = 1'b0;
      expd = 1'b0;
    end else begin
      if (expd)
        chk(done && in_ready, "R7", "done with in_ready after last block",
            longint'({done, in_ready}), 3);
      else if (done)
        chk(1'b0, "R7", "done outside its slot", longint'(done), 0);
      expd = 1'b0;
      if (stall)
        chk(out_valid && out_data == hold_d, "R5", "stalled block held",
            longint'(out_data), longint'(hold_d));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = lfsr[0];
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected output block", longint'(out_data), 0);
        end else begin
          logic [64:0] it;
          it = exp_q.pop_front();
          chk(out_data == it[63:0], "R1", "output block", longint'(out_data),
              longint'(it[63:0]));
          expd = it[64];
        end
      end
      stall = out_valid && !out_ready;
      hold_d = out_data;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=hung expected=complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready && !out_valid && !done, "R10", "outputs during reset",
        longint'({in_ready, out_valid, done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !done, "R10", "outputs after reset",
        longint'({in_ready, out_valid, done}), 4);
    chk(in_ready && !out_valid, "R4", "idle accepts input",
        longint'({in_ready, out_valid}), 2);

    // R1 R9: impulse in column 0 picks out the first columns of row-blocks
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = 0;
    xbuf[0][0] = 1;
    rmode = 0;
    send_vec(0);
    // R9: impulse in the last column tests arrival order
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = 0;
    xbuf[COLS-1][2] = 3;
    send_vec(1);
    // R5 R8: ramp with alternating back-pressure
    rmode = 1;
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = c * 4 + j + 1;
    send_vec(0);
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = -7 * (3 * c + j);
    send_vec(2);
    // R3: full-scale inputs drive both saturation limits
    rmode = 2;
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = 32767;
    send_vec(0);
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) xbuf[c][j] = -32768;
    send_vec(0);
    for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++)
      xbuf[c][j] = ((j % 2) == 0) ? 32767 : -32768;
    send_vec(1);
    // R9: pseudo-random vectors back to back
    for (int v = 0; v < 6; v++) begin
      for (int c = 0; c < COLS; c++) for (int j = 0; j < 4; j++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        xbuf[c][j] = int'($signed(lfsr[11:0])) - 100 * v;
      end
      send_vec(v % 3);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R4", "idle after last vector",
        longint'({in_ready, out_valid}), 2);
    summary();
  end
endmodule